// File: doc/BRIEF.md
# Backplane Bus Mastership Controller

This block decides whether the device drives the clock and frame lines of a shared TDM backplane that has two redundant buses, A and B. A two-bit role input selects one of four roles: master on A, master on B, backup on A or backup on B. A master turns on the output drivers of its selected bus. A backup keeps both drivers off and follows the timing of the active master. It also watches the clock-error and frame-error flags from the bus clock monitor. Generating the clocks themselves is left to other logic.

While it is a backup, the block counts consecutive frames in which the monitor reported a clock or frame fault. When `FAIL_FRAMES` such frames occur in a row, the block is promoted. It switches its timing reference to the local source and turns on the driver of its selected bus. Role, per-bus override bits and the driver enables are only taken up at a frame boundary, so the bus never sees a partial pulse. The override bits hold a bus driver off in any role. One more path sets the polarity of the frame compatibility output.

The state machine has three states. `ST_MASTER` is a configured master. `ST_MONITOR` is a backup watching the master, and it is also the state after reset. `ST_PROMOTED` is a backup that has taken over. The transitions are evaluated only on a `frame_tick`:
- A master role leads to `ST_MASTER` from any state. This is the "assume" transition.
- `ST_MASTER` moves to `ST_MONITOR` when the role is a backup. This is the "demote" transition.
- `ST_MONITOR` moves to `ST_PROMOTED` when the failure count reaches its limit. This is the "promote" transition.
- `ST_PROMOTED` holds while the role stays a backup. This is the "hold" transition.

Top module: `bus_mastership_ctrl`

## Requirements
- R1: Role encoding is as follows. role[1]=0 means master and 1 means backup. role[0]=0 selects bus A and 1 selects bus B. After a frame_tick with a master role, state_o is 2'b00, the selected bus enable is 1, the other enable is 0 and ref_local is 1. drv_en_a and drv_en_b are never 1 together.
- R2: After a frame_tick with a backup role while in ST_MASTER, the state becomes ST_MONITOR (state_o 2'b01). In that state both enables and ref_local are 0.
- R3: drv_en_a, drv_en_b, ref_local and state_o change only in the cycle that follows a frame_tick. Role and override inputs that change mid-frame have no effect until the next tick.
- R4: A frame is failed if clk_err or frame_err is 1 in any cycle from the cycle after the previous tick up to and including its own tick cycle. After FAIL_FRAMES consecutive failed frames in ST_MONITOR (default 2), the state becomes ST_PROMOTED (2'b10). ref_local is then 1 and the selected bus enable is 1.
- R5: A clean frame in ST_MONITOR restarts the consecutive-failure count from zero.
- R6: ST_PROMOTED holds while the role at each tick is a backup, and follows role[0] for the bus choice. A master role at a tick moves any state to ST_MASTER.
- R7: override_a (override_b), when sampled at a tick, holds drv_en_a (drv_en_b) at 0 for the next frame in any state, and it does not change the state.
- R8: promo_sticky is set by the promotion and stays 1 until reset.
- R9: frame_comp equals frame_raw when frame_pol is 1 and ~frame_raw when frame_pol is 0, with no delay.
- R10: During and directly after reset the state is ST_MONITOR, both enables, ref_local and promo_sticky are 0, and the latched role is backup on A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| role | input | 2 | Configured role: bit1 backup, bit0 bus B |
| frame_tick | input | 1 | One-cycle frame boundary pulse |
| clk_err | input | 1 | Clock fault flag from the bus monitor |
| frame_err | input | 1 | Frame fault flag from the bus monitor |
| override_a | input | 1 | Force bus A drivers off |
| override_b | input | 1 | Force bus B drivers off |
| frame_raw | input | 1 | Internal active-high frame pulse |
| frame_pol | input | 1 | Frame output polarity: 1 active high |
| drv_en_a | output | 1 | Bus A clock/frame driver enable |
| drv_en_b | output | 1 | Bus B clock/frame driver enable |
| ref_local | output | 1 | 1: track local reference, 0: follow bus master |
| state_o | output | 2 | 00 master, 01 monitoring, 10 promoted |
| promo_sticky | output | 1 | Set on promotion, cleared by reset |
| frame_comp | output | 1 | Frame compatibility output with programmed polarity |

## Verification
The bench runs directed role sequences for each of the four roles. It puts a single error frame between clean frames to separate a count that restarts from one that only accumulates. It puts an error on the tick cycle itself to confirm that cycle belongs to the closing frame. It also changes the role mid-frame to show that nothing moves before the boundary. Random traffic then mixes role changes, overrides, sparse errors and irregular tick spacing, and every cycle is compared with a bench model. This exposes any early, late or mis-steered enable.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
    typedef enum logic [1:0] {
        ST_MASTER   = 2'b00,
        ST_MONITOR  = 2'b01,
        ST_PROMOTED = 2'b10
    } bmc_state_e;

    localparam logic [1:0] ROLE_RESET = 2'b10;
endpackage

// File: rtl/bmc_fail_count.sv
module bmc_fail_count #(
    parameter int FAIL_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_tick,
    input  logic armed,
    input  logic err_in,
    output logic fail_hit
);
    localparam int CW = $clog2(FAIL_FRAMES + 1);
    localparam logic [CW-1:0] LIMIT_M1 = CW'(FAIL_FRAMES - 1);

    logic [CW-1:0] run_q;
    logic          err_lat_q;
    logic          err_now;

    // errors seen anywhere in the frame, including the tick cycle
    assign err_now  = err_lat_q | err_in;
    assign fail_hit = frame_tick & armed & err_now & (run_q >= LIMIT_M1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q     <= '0;
            err_lat_q <= 1'b0;
        end else if (frame_tick) begin
            err_lat_q <= 1'b0;
            if (!armed || !err_now || fail_hit)
                run_q <= '0;
            else
                run_q <= run_q + 1'b1;
        end else begin
            err_lat_q <= err_now;
        end
    end
endmodule

// File: rtl/bmc_frame_pol.sv
module bmc_frame_pol (
    input  logic frame_raw,
    input  logic frame_pol,
    output logic frame_comp
);
    assign frame_comp = frame_pol ? frame_raw : ~frame_raw;
endmodule

// File: rtl/bus_mastership_ctrl.sv
module bus_mastership_ctrl
    import bmc_pkg::*;
#(
    parameter int FAIL_FRAMES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] role,
    input  logic       frame_tick,
    input  logic       clk_err,
    input  logic       frame_err,
    input  logic       override_a,
    input  logic       override_b,
    input  logic       frame_raw,
    input  logic       frame_pol,
    output logic       drv_en_a,
    output logic       drv_en_b,
    output logic       ref_local,
    output logic [1:0] state_o,
    output logic       promo_sticky
    ,output logic      frame_comp
);
    bmc_state_e state_q, state_d;
    logic [1:0] role_q;
    logic       ovr_a_q, ovr_b_q;
    logic       sticky_q;
    logic       fail_hit;
    logic       armed;
    logic       drv_on;

    assign armed = (state_q == ST_MONITOR) & role[1];

    bmc_fail_count #(.FAIL_FRAMES(FAIL_FRAMES)) u_fail (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_tick (frame_tick),
        .armed      (armed),
        .err_in     (clk_err | frame_err),
        .fail_hit   (fail_hit)
    );

    bmc_frame_pol u_pol (
        .frame_raw  (frame_raw),
        .frame_pol  (frame_pol),
        .frame_comp (frame_comp)
    );

    // next-state: decided only on a frame boundary
    always_comb begin
        state_d = state_q;
        if (frame_tick) begin
            if (!role[1]) begin
                state_d = ST_MASTER;
            end else begin
                unique case (state_q)
                    ST_MASTER:   state_d = ST_MONITOR;
                    ST_MONITOR:  state_d = fail_hit ? ST_PROMOTED : ST_MONITOR;
                    ST_PROMOTED: state_d = ST_PROMOTED;
                    default:     state_d = ST_MONITOR;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_MONITOR;
            role_q   <= ROLE_RESET;
            ovr_a_q  <= 1'b0;
            ovr_b_q  <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (frame_tick) begin
                role_q  <= role;
                ovr_a_q <= override_a;
                ovr_b_q <= override_b;
            end
            if (fail_hit)
                sticky_q <= 1'b1;
        end
    end

    always_comb begin
        drv_on       = (state_q != ST_MONITOR);
        drv_en_a     = drv_on & ~role_q[0] & ~ovr_a_q;
        drv_en_b     = drv_on &  role_q[0] & ~ovr_b_q;
        ref_local    = drv_on;
        state_o      = state_q;
        promo_sticky = sticky_q;
    end
endmodule

// File: rtl/bmc_checker.sv
module bmc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] role,
    input logic       frame_tick,
    input logic       override_a,
    input logic       override_b,
    input logic       drv_en_a,
    input logic       drv_en_b,
    input logic       ref_local,
    input logic [1:0] state_o,
    input logic       promo_sticky
);
    // R1
    one_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_en_a && drv_en_b));

    // R2
    monitor_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b01) |-> (!drv_en_a && !drv_en_b && !ref_local));

    // R3
    frame_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> ($stable(drv_en_a) && $stable(drv_en_b) && $stable(state_o)));

    // R6
    master_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !role[1]) |=> (state_o == 2'b00));

    // R7
    override_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && override_a) |=> !drv_en_a);

    // R7
    override_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && override_b) |=> !drv_en_b);

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        promo_sticky |=> promo_sticky);

    // R4
    promoted_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b10) |-> (promo_sticky && ref_local));
endmodule

bind bus_mastership_ctrl bmc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .role         (role),
    .frame_tick   (frame_tick),
    .override_a   (override_a),
    .override_b   (override_b),
    .drv_en_a     (drv_en_a),
    .drv_en_b     (drv_en_b),
    .ref_local    (ref_local),
    .state_o      (state_o),
    .promo_sticky (promo_sticky)
);

// File: tb/bus_mastership_ctrl_test.sv
module bus_mastership_ctrl_test;
    localparam int FAILS = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] role = 2'b10;
    logic       frame_tick = 1'b0, clk_err = 1'b0, frame_err = 1'b0;
    logic       override_a = 1'b0, override_b = 1'b0;
    logic       frame_raw = 1'b0, frame_pol = 1'b0;
    logic       drv_en_a, drv_en_b, ref_local, promo_sticky, frame_comp;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;
    bit done = 1'b0;

    // bench model of the requirements
    logic [1:0] m_state = 2'b01;
    logic [1:0] m_role = 2'b10;
    logic       m_oa = 1'b0, m_ob = 1'b0, m_errlat = 1'b0, m_sticky = 1'b0;
    int         m_run = 0;

    always #2.5 clk = ~clk;

    bus_mastership_ctrl #(.FAIL_FRAMES(FAILS)) uut (
        .clk(clk), .rst_n(rst_n), .role(role), .frame_tick(frame_tick),
        .clk_err(clk_err), .frame_err(frame_err),
        .override_a(override_a), .override_b(override_b),
        .frame_raw(frame_raw), .frame_pol(frame_pol),
        .drv_en_a(drv_en_a), .drv_en_b(drv_en_b), .ref_local(ref_local),
        .state_o(state_o), .promo_sticky(promo_sticky), .frame_comp(frame_comp)
    );

    function automatic logic exp_en(logic [1:0] st, logic [1:0] rl, logic bus_b, logic ovr);
        return (st != 2'b01) && (rl[0] == bus_b) && !ovr;
    endfunction

    function automatic logic exp_comp(logic raw, logic pol);
        return pol ? raw : ~raw;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state <= 2'b01; m_role <= 2'b10; m_oa <= 1'b0; m_ob <= 1'b0;
            m_errlat <= 1'b0; m_sticky <= 1'b0; m_run <= 0;
        end else if (frame_tick) begin
            m_errlat <= 1'b0;
            m_role <= role; m_oa <= override_a; m_ob <= override_b;
            if (!role[1]) begin
                m_state <= 2'b00; m_run <= 0;
            end else if (m_state == 2'b00) begin
                m_state <= 2'b01; m_run <= 0;
            end else if (m_state == 2'b01) begin
                if (m_errlat || clk_err || frame_err) begin
                    if (m_run + 1 >= FAILS) begin
                        m_state <= 2'b10; m_sticky <= 1'b1; m_run <= 0;
                    end else m_run <= m_run + 1;
                end else m_run <= 0;
            end
        end else begin
            m_errlat <= m_errlat | clk_err | frame_err;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        if (model_on && rst_n) begin
            chk("R3", {3'b0, drv_en_a, drv_en_b, ref_local, state_o},
                {3'b0, exp_en(m_state, m_role, 1'b0, m_oa), exp_en(m_state, m_role, 1'b1, m_ob),
                 (m_state != 2'b01), m_state});
            chk("R8", {7'b0, promo_sticky}, {7'b0, m_sticky});
            chk("R9", {7'b0, frame_comp}, {7'b0, exp_comp(frame_raw, frame_pol)});
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic tick_frame();
        frame_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0;
    endtask

    task automatic err_frame();
        clk_err = 1'b1; @(negedge clk); clk_err = 1'b0;
        idle(2);
        tick_frame();
    endtask

    task automatic check_out(string req, logic a, logic b, logic r, logic [1:0] s);
        chk(req, {4'b0, drv_en_a, drv_en_b, state_o}, {4'b0, a, b, s});
        chk(req, {7'b0, ref_local}, {7'b0, r});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        idle(3);
        // R10 reset state
        check_out("R10", 1'b0, 1'b0, 1'b0, 2'b01);
        chk("R10", {7'b0, promo_sticky}, 8'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out("R10", 1'b0, 1'b0, 1'b0, 2'b01);
        model_on = 1'b1;

        // R1 master on A, then on B
        role = 2'b00; idle(2); tick_frame();
        check_out("R1", 1'b1, 1'b0, 1'b1, 2'b00);
        role = 2'b01; idle(2); tick_frame();
        check_out("R1", 1'b0, 1'b1, 1'b1, 2'b00);

        // R2 demote to monitoring
        role = 2'b10; idle(1); tick_frame();
        check_out("R2", 1'b0, 1'b0, 1'b0, 2'b01);

        // R3 mid-frame role change has no effect before the tick
        role = 2'b00; idle(4);
        check_out("R3", 1'b0, 1'b0, 1'b0, 2'b01);
        tick_frame();
        check_out("R3", 1'b1, 1'b0, 1'b1, 2'b00);

        // R5 error, clean, error: no promotion
        role = 2'b11; tick_frame();
        err_frame();
        idle(2); tick_frame();
        err_frame();
        check_out("R5", 1'b0, 1'b0, 1'b0, 2'b01);
        // R4 second consecutive failure, raised on the tick cycle itself
        idle(2); frame_err = 1'b1; tick_frame(); frame_err = 1'b0;
        check_out("R4", 1'b0, 1'b1, 1'b1, 2'b10);
        chk("R8", {7'b0, promo_sticky}, 8'h1);

        // R6 promoted holds and follows bus choice, master role leaves it
        role = 2'b10; idle(1); tick_frame();
        check_out("R6", 1'b1, 1'b0, 1'b1, 2'b10);
        role = 2'b00; tick_frame();
        check_out("R6", 1'b1, 1'b0, 1'b1, 2'b00);
        role = 2'b10; tick_frame();
        check_out("R6", 1'b0, 1'b0, 1'b0, 2'b01);
        chk("R8", {7'b0, promo_sticky}, 8'h1);

        // R7 override holds a master's driver off, state unchanged
        role = 2'b00; override_a = 1'b1; tick_frame();
        check_out("R7", 1'b0, 1'b0, 1'b1, 2'b00);
        override_a = 1'b0; idle(3);
        check_out("R7", 1'b0, 1'b0, 1'b1, 2'b00);
        tick_frame();
        check_out("R7", 1'b1, 1'b0, 1'b1, 2'b00);

        // R9 polarity combinations
        for (int k = 0; k < 4; k++) begin
            frame_pol = k[1]; frame_raw = k[0]; #1;
            chk("R9", {7'b0, frame_comp}, {7'b0, exp_comp(k[0], k[1])});
            @(negedge clk);
        end

        // random traffic, checked every cycle against the model (R3)
        for (int n = 0; n < 4000; n++) begin
            frame_tick = ($urandom % 8) == 0;
            clk_err    = ($urandom % 6) == 0;
            frame_err  = ($urandom % 9) == 0;
            frame_raw  = $urandom;
            frame_pol  = $urandom;
            if (($urandom % 20) == 0) role = 2'($urandom);
            if (($urandom % 15) == 0) override_a = ($urandom % 4) == 0;
            if (($urandom % 15) == 0) override_b = ($urandom % 4) == 0;
            @(negedge clk);
        end
        frame_tick = 1'b0;
        idle(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule